// File: doc/BRIEF.md
# USB Device Endpoint Transaction Controller

This block makes the transaction decisions of a full-speed USB device. A lower layer hands it packets that are already decoded. A token arrives as a PID byte with a device address and an endpoint number. The end of a received data phase arrives with a good or bad flag. A handshake received from the host arrives as a PID byte. The block has four endpoints. For each one it holds a buffer-full flag and an interrupt bit. It also takes an enable bit and an isochronous flag per endpoint as configuration inputs. From these it decides one of three things: start sending the endpoint buffer, accept incoming data into the buffer, or answer with an ACK or NAK handshake.

An OUT transfer is one the host sends to the device. An IN transfer is one the device sends to the host. The full flag alone decides between moving data and answering NAK. An IN buffer must be full to be sent. An OUT buffer must be empty to accept data. A normal IN endpoint completes only when the host's ACK arrives. An isochronous endpoint completes as soon as its data phase ends, because it has no handshake phase. When a transaction completes, the endpoint's full flag flips and its interrupt bit is set. The processor then refills or drains the buffer through the fill and drain strobes, and clears the interrupt by writing a 1 to it.

The control is one state machine with four states:
- `ST_IDLE` waits for a token.
- `ST_IN_SEND` holds the buffer read while the lower layer transmits.
- `ST_IN_ACKWAIT` counts cycles while waiting for the host's ACK.
- `ST_OUT_RX` holds the buffer write, when the data is accepted, until the data phase ends.

Its transitions are:
- Idle to in-send: a matching IN token for a full endpoint.
- Idle to out-receive: any matching OUT token.
- In-send to ack-wait: the data is sent on a normal endpoint.
- In-send to idle: the data is sent on an isochronous endpoint. The endpoint completes on this transition.
- Ack-wait to idle: an ACK arrives (the endpoint completes), another handshake or token arrives, or the timeout runs out.
- Out-receive to idle: the data phase ends.

Top module: `usb_ep_txn_ctrl`

## Requirements
- R1: After reset, all full flags and all interrupt bits are 0, and `hs_tx_valid`, `data_tx_en`, `buf_rd_en` and `buf_wr_en` are low.
- R2: The block ignores any token whose upper PID nibble is not the bitwise inverse of its lower nibble. It sends no data and no handshake in reply.
- R3: The block answers a token only when `tok_addr` equals `dev_addr`, `tok_ep` is below 4, and that endpoint's `ep_enable` bit is 1. Otherwise it does nothing.
- R4: On a valid IN token (lower nibble 4'b1001) for a full endpoint, `data_tx_en` and that endpoint's bit of `buf_rd_en` are high from the cycle after the token until the edge where `tx_done` is seen.
- R5: On a valid IN token for an empty endpoint, the block sends a one-cycle `hs_tx_valid` pulse with `hs_tx_pid` = 8'h5A (NAK) in the cycle after the token.
- R6: On a normal IN endpoint, the full flag stays set and the interrupt bit stays clear after `tx_done`. Both change, to empty and to set, at the edge where an ACK handshake (8'hD2) is received.
- R7: On an isochronous IN endpoint, the full flag clears and the interrupt bit sets at the edge where `tx_done` is seen. No handshake is waited for.
- R8: If no ACK arrives within `ACK_TIMEOUT` cycles after `tx_done`, the buffer stays full and no interrupt is raised. A later ACK has no effect, and the next IN token sends the same buffer again.
- R9: On a valid OUT token (lower nibble 4'b0001) for an empty normal endpoint, the block does three things. It drives that endpoint's bit of `buf_wr_en` during the data phase. It pulses `hs_tx_pid` = 8'hD2 (ACK) in the cycle after a good `dat_done`. At that same edge it sets the full flag and the interrupt bit.
- R10: An OUT token for a full endpoint gives no write strobe and leaves the full flag and interrupt unchanged. A normal endpoint answers with NAK (8'h5A) after `dat_done`. An isochronous endpoint sends nothing.
- R11: On an isochronous OUT endpoint that is empty, a good `dat_done` sets the full flag and the interrupt bit, and no handshake is sent.
- R12: An OUT data phase that ends with `dat_good` low gives no handshake and leaves the full flag and interrupt unchanged.
- R13: A 1 on `irq_clr[i]` clears interrupt bit i. `cpu_fill[i]` sets full flag i and `cpu_drain[i]` clears it. If a completion and a clear hit the same endpoint in the same cycle, the interrupt is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_addr | input | 7 | Device address assigned to this function |
| ep_enable | input | 4 | Per-endpoint enable |
| ep_iso | input | 4 | Per-endpoint isochronous flag |
| tok_valid | input | 1 | One-cycle strobe: token decoded |
| tok_pid | input | 8 | Token PID byte, check nibble above |
| tok_addr | input | 7 | Token device address field |
| tok_ep | input | 4 | Token endpoint field |
| tx_done | input | 1 | Lower layer finished sending the IN data packet |
| dat_done | input | 1 | Received OUT data phase ended |
| dat_good | input | 1 | Received data phase was good (qualifies `dat_done`) |
| hs_valid | input | 1 | Strobe: handshake received from the host |
| hs_pid | input | 8 | Received handshake PID byte |
| cpu_fill | input | 4 | Processor marks buffer full |
| cpu_drain | input | 4 | Processor marks buffer empty |
| irq_clr | input | 4 | Write-one-to-clear for interrupt bits |
| data_tx_en | output | 1 | Send the selected buffer now |
| buf_rd_en | output | 4 | One-hot buffer read select during IN data |
| buf_wr_en | output | 4 | One-hot buffer write select during accepted OUT data |
| hs_tx_valid | output | 1 | One-cycle request to send a handshake |
| hs_tx_pid | output | 8 | Handshake PID byte to send |
| ep_full | output | 4 | Per-endpoint buffer full flags |
| ep_irq | output | 4 | Per-endpoint interrupt bits |

## Verification
The assertions that tie `buf_rd_en` and `buf_wr_en` to the full flags assume two things about the processor. It never drains an endpoint while that endpoint's IN data is being sent, and it never fills an endpoint while that endpoint's OUT data is being written. The stimulus keeps to this by touching the fill, drain and clear strobes only while the controller is idle, and by asserting the clear alone in the one test that overlaps a completion. The bench also gives only one-cycle strobes. It never raises `tx_done` or `dat_done` outside the phase that expects them.

// File: rtl/usb_txn_pkg.sv
package usb_txn_pkg;

    localparam logic [3:0] PID_IN  = 4'b1001;
    localparam logic [3:0] PID_OUT = 4'b0001;
    localparam logic [3:0] PID_ACK = 4'b0010;
    localparam logic [3:0] PID_NAK = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IN_SEND,
        ST_IN_ACKWAIT,
        ST_OUT_RX
    } txn_state_e;

    function automatic logic [7:0] pid_to_byte(input logic [3:0] code);
        return {~code, code};
    endfunction

endpackage

// File: rtl/usb_txn_pid_check.sv
module usb_txn_pid_check (
    input  logic       strobe,
    input  logic [7:0] pid_byte,
    output logic       ok,
    output logic [3:0] code
);
    // A PID is trusted only when its upper nibble inverts its lower one
    assign ok   = strobe && (pid_byte[7:4] == ~pid_byte[3:0]);
    assign code = pid_byte[3:0];
endmodule

// File: rtl/usb_txn_ep_status.sv
module usb_txn_ep_status #(
    parameter int NEP = 4,
    parameter int EPW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_done,
    input  logic           out_done,
    input  logic [EPW-1:0] evt_ep,
    input  logic [NEP-1:0] cpu_fill,
    input  logic [NEP-1:0] cpu_drain,
    input  logic [NEP-1:0] irq_clr,
    output logic [NEP-1:0] ep_full,
    output logic [NEP-1:0] ep_irq
);

    for (genvar i = 0; i < NEP; i++) begin : g_ep
        logic full_q;
        logic irq_q;
        logic hit;

        assign hit = (evt_ep == EPW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q <= 1'b0;
                irq_q  <= 1'b0;
            end else begin
                // engine completion outranks processor strobes
                if (in_done && hit)        full_q <= 1'b0;
                else if (out_done && hit)  full_q <= 1'b1;
                else if (cpu_fill[i])      full_q <= 1'b1;
                else if (cpu_drain[i])     full_q <= 1'b0;

                if ((in_done || out_done) && hit) irq_q <= 1'b1;
                else if (irq_clr[i])              irq_q <= 1'b0;
            end
        end

        assign ep_full[i] = full_q;
        assign ep_irq[i]  = irq_q;

        // R13: an interrupt bit only rises after a transaction completed
        a_r13_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ep_irq[i]) |-> $past(in_done || out_done));
    end

endmodule

// File: rtl/usb_txn_fsm.sv
module usb_txn_fsm
    import usb_txn_pkg::*;
#(
    parameter int NEP         = 4,
    parameter int EPW         = 2,
    parameter int ACK_TIMEOUT = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tok_in,
    input  logic           tok_out,
    input  logic           tok_any,
    input  logic [EPW-1:0] tok_ep,
    input  logic           tx_done,
    input  logic           dat_done,
    input  logic           dat_good,
    input  logic           hs_ack,
    input  logic           hs_other,
    input  logic [NEP-1:0] ep_full,
    input  logic [NEP-1:0] ep_iso,
    output logic           data_tx_en,
    output logic [NEP-1:0] rd_en,
    output logic [NEP-1:0] wr_en,
    output logic           in_done,
    output logic           out_done,
    output logic [EPW-1:0] evt_ep,
    output logic           hs_tx_valid,
    output logic [7:0]     hs_tx_pid
);

    localparam int CNTW = $clog2(ACK_TIMEOUT + 1);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(ACK_TIMEOUT - 1);

    txn_state_e     state, state_n;
    logic [EPW-1:0] cur_ep, cur_ep_n;
    logic           accept, accept_n;
    logic [CNTW-1:0] cnt, cnt_n;
    logic           hs_req;
    logic [3:0]     hs_code;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ep <= '0;
            accept <= 1'b0;
            cnt    <= '0;
        end else begin
            state  <= state_n;
            cur_ep <= cur_ep_n;
            accept <= accept_n;
            cnt    <= cnt_n;
        end
    end

    // transitions and completion events
    always_comb begin
        state_n  = state;
        cur_ep_n = cur_ep;
        accept_n = accept;
        cnt_n    = cnt;
        in_done  = 1'b0;
        out_done = 1'b0;
        hs_req   = 1'b0;
        hs_code  = PID_ACK;
        unique case (state)
            ST_IDLE: begin
                if (tok_in) begin
                    if (ep_full[tok_ep]) begin
                        state_n  = ST_IN_SEND;
                        cur_ep_n = tok_ep;
                    end else begin
                        hs_req  = 1'b1;
                        hs_code = PID_NAK;
                    end
                end else if (tok_out) begin
                    state_n  = ST_OUT_RX;
                    cur_ep_n = tok_ep;
                    accept_n = !ep_full[tok_ep];
                end
            end
            ST_IN_SEND: begin
                if (tx_done) begin
                    if (ep_iso[cur_ep]) begin
                        in_done = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        state_n = ST_IN_ACKWAIT;
                        cnt_n   = '0;
                    end
                end
            end
            ST_IN_ACKWAIT: begin
                if (hs_ack) begin
                    in_done = 1'b1;
                    state_n = ST_IDLE;
                end else if (hs_other || tok_any || cnt == CNT_LAST) begin
                    state_n = ST_IDLE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_OUT_RX: begin
                if (dat_done) begin
                    state_n = ST_IDLE;
                    if (dat_good) begin
                        if (accept) begin
                            out_done = 1'b1;
                            hs_req   = !ep_iso[cur_ep];
                        end else begin
                            hs_req  = !ep_iso[cur_ep];
                            hs_code = PID_NAK;
                        end
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign evt_ep = cur_ep;

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_tx_valid <= 1'b0;
            hs_tx_pid   <= '0;
        end else begin
            hs_tx_valid <= hs_req;
            hs_tx_pid   <= hs_req ? pid_to_byte(hs_code) : 8'h00;
        end
    end

    assign data_tx_en = (state == ST_IN_SEND);

    for (genvar i = 0; i < NEP; i++) begin : g_strobe
        assign rd_en[i] = (state == ST_IN_SEND) && (cur_ep == EPW'(i));
        assign wr_en[i] = (state == ST_OUT_RX) && accept && (cur_ep == EPW'(i));
    end

    // R4: data only leaves a buffer that the status logic holds full
    a_r4_send_from_full: assert property (@(posedge clk) disable iff (!rst_n)
        data_tx_en |-> ((rd_en & ep_full) != '0));

    // R10: a write strobe never targets a full buffer
    a_r10_write_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> ((wr_en & ep_full) == '0));

    // R5: only ACK or NAK leave as handshakes
    a_r5_hs_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        hs_tx_valid |-> (hs_tx_pid == 8'hD2 || hs_tx_pid == 8'h5A));

    // R8: the ACK wait never outlives its window
    a_r8_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IN_ACKWAIT) |-> (int'(cnt) < ACK_TIMEOUT));

endmodule

// File: rtl/usb_ep_txn_ctrl.sv
module usb_ep_txn_ctrl
    import usb_txn_pkg::*;
#(
    parameter int NEP         = 4,
    parameter int ACK_TIMEOUT = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [6:0]     dev_addr,
    input  logic [NEP-1:0] ep_enable,
    input  logic [NEP-1:0] ep_iso,
    input  logic           tok_valid,
    input  logic [7:0]     tok_pid,
    input  logic [6:0]     tok_addr,
    input  logic [3:0]     tok_ep,
    input  logic           tx_done,
    input  logic           dat_done,
    input  logic           dat_good,
    input  logic           hs_valid,
    input  logic [7:0]     hs_pid,
    input  logic [NEP-1:0] cpu_fill,
    input  logic [NEP-1:0] cpu_drain,
    input  logic [NEP-1:0] irq_clr,
    output logic           data_tx_en,
    output logic [NEP-1:0] buf_rd_en,
    output logic [NEP-1:0] buf_wr_en,
    output logic           hs_tx_valid,
    output logic [7:0]     hs_tx_pid,
    output logic [NEP-1:0] ep_full,
    output logic [NEP-1:0] ep_irq
);

    localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1;

    logic           tok_ok, hs_ok;
    logic [3:0]     tok_code, hs_code;
    logic [EPW-1:0] ep_idx;
    logic           target_hit;
    logic           tok_in, tok_out;
    logic           in_done, out_done;
    logic [EPW-1:0] evt_ep;

    usb_txn_pid_check u_tok_chk (
        .strobe  (tok_valid),
        .pid_byte(tok_pid),
        .ok      (tok_ok),
        .code    (tok_code)
    );

    usb_txn_pid_check u_hs_chk (
        .strobe  (hs_valid),
        .pid_byte(hs_pid),
        .ok      (hs_ok),
        .code    (hs_code)
    );

    assign ep_idx     = tok_ep[EPW-1:0];
    assign target_hit = (tok_addr == dev_addr) && (int'(tok_ep) < NEP) && ep_enable[ep_idx];
    assign tok_in     = tok_ok && target_hit && (tok_code == PID_IN);
    assign tok_out    = tok_ok && target_hit && (tok_code == PID_OUT);

    usb_txn_fsm #(
        .NEP        (NEP),
        .EPW        (EPW),
        .ACK_TIMEOUT(ACK_TIMEOUT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_in     (tok_in),
        .tok_out    (tok_out),
        .tok_any    (tok_ok),
        .tok_ep     (ep_idx),
        .tx_done    (tx_done),
        .dat_done   (dat_done),
        .dat_good   (dat_good),
        .hs_ack     (hs_ok && hs_code == PID_ACK),
        .hs_other   (hs_ok && hs_code != PID_ACK),
        .ep_full    (ep_full),
        .ep_iso     (ep_iso),
        .data_tx_en (data_tx_en),
        .rd_en      (buf_rd_en),
        .wr_en      (buf_wr_en),
        .in_done    (in_done),
        .out_done   (out_done),
        .evt_ep     (evt_ep),
        .hs_tx_valid(hs_tx_valid),
        .hs_tx_pid  (hs_tx_pid)
    );

    usb_txn_ep_status #(
        .NEP(NEP),
        .EPW(EPW)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_done  (in_done),
        .out_done (out_done),
        .evt_ep   (evt_ep),
        .cpu_fill (cpu_fill),
        .cpu_drain(cpu_drain),
        .irq_clr  (irq_clr),
        .ep_full  (ep_full),
        .ep_irq   (ep_irq)
    );

endmodule

// File: tb/sim_usb_ep_txn_ctrl.sv
`timescale 1ns/1ps
module sim_usb_ep_txn_ctrl;

    localparam int TMO  = 16;
    localparam logic [6:0] ADDR = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] dev_addr = ADDR;
    logic [3:0] ep_enable = 4'b0111;
    logic [3:0] ep_iso = 4'b0100;
    logic       tok_valid = 1'b0;
    logic [7:0] tok_pid = '0;
    logic [6:0] tok_addr = '0;
    logic [3:0] tok_ep = '0;
    logic       tx_done = 1'b0;
    logic       dat_done = 1'b0;
    logic       dat_good = 1'b0;
    logic       hs_valid = 1'b0;
    logic [7:0] hs_pid = '0;
    logic [3:0] cpu_fill = '0;
    logic [3:0] cpu_drain = '0;
    logic [3:0] irq_clr = '0;
    logic       data_tx_en;
    logic [3:0] buf_rd_en, buf_wr_en;
    logic       hs_tx_valid;
    logic [7:0] hs_tx_pid;
    logic [3:0] ep_full, ep_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usb_ep_txn_ctrl #(.NEP(4), .ACK_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .ep_enable(ep_enable),
        .ep_iso(ep_iso), .tok_valid(tok_valid), .tok_pid(tok_pid),
        .tok_addr(tok_addr), .tok_ep(tok_ep), .tx_done(tx_done),
        .dat_done(dat_done), .dat_good(dat_good), .hs_valid(hs_valid),
        .hs_pid(hs_pid), .cpu_fill(cpu_fill), .cpu_drain(cpu_drain),
        .irq_clr(irq_clr), .data_tx_en(data_tx_en), .buf_rd_en(buf_rd_en),
        .buf_wr_en(buf_wr_en), .hs_tx_valid(hs_tx_valid), .hs_tx_pid(hs_tx_pid),
        .ep_full(ep_full), .ep_irq(ep_irq)
    );

    typedef struct packed {
        logic       is_out;
        logic [1:0] ep;
        logic       pre_full;
        logic       good;
        logic       ack;
        logic       exp_data;
        logic       exp_wr;
        logic [7:0] exp_hs;
        logic       exp_full;
        logic       exp_irq;
    } vec_t;

    // ep0/ep1 normal, ep2 isochronous, ep3 disabled
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
        '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0},
        '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
        '{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hD2, 1'b1, 1'b1},
        '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b0},
        '{1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
        '{1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0},
        '{1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0},
        '{1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
        '{1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
    };
    localparam string VTAG [NV] = '{"R6", "R5", "R7", "R9", "R10", "R11",
                                    "R10", "R12", "R5", "R3", "R3"};

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic preset(int ep, logic full);
        irq_clr = '1;
        if (full) cpu_fill[ep] = 1'b1; else cpu_drain[ep] = 1'b1;
        tick();
        irq_clr = '0; cpu_fill = '0; cpu_drain = '0;
    endtask

    task automatic send_tok(logic [7:0] pid, logic [6:0] addr, logic [3:0] ep);
        tok_valid = 1'b1; tok_pid = pid; tok_addr = addr; tok_ep = ep;
        tick();
        tok_valid = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1; tick(); tx_done = 1'b0;
    endtask

    task automatic pulse_dat(logic good);
        dat_done = 1'b1; dat_good = good; tick(); dat_done = 1'b0; dat_good = 1'b0;
    endtask

    task automatic pulse_hs(logic [7:0] pid);
        hs_valid = 1'b1; hs_pid = pid; tick(); hs_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        check("R1", "full", 32'(ep_full), 32'h0);
        check("R1", "irq", 32'(ep_irq), 32'h0);
        check("R1", "outputs", {28'h0, hs_tx_valid, data_tx_en, |buf_rd_en, |buf_wr_en}, 32'h0);
        rst_n = 1'b1;
        tick();

        // table walk
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            preset(int'(t.ep), t.pre_full);
            send_tok(t.is_out ? 8'hE1 : 8'h69, ADDR, {2'b00, t.ep});
            if (!t.is_out) begin
                check(VTAG[v], "hs valid", 32'(hs_tx_valid), 32'(t.exp_hs != 8'h00));
                if (t.exp_hs != 8'h00) check(VTAG[v], "hs pid", 32'(hs_tx_pid), 32'(t.exp_hs));
                check(VTAG[v], "data_tx_en", 32'(data_tx_en), 32'(t.exp_data));
                if (t.exp_data) begin
                    check("R4", "rd_en", 32'(buf_rd_en), 32'(4'b0001 << t.ep));
                    pulse_tx();
                    if (t.ack) pulse_hs(8'hD2);
                end
            end else begin
                check(VTAG[v], "wr_en", 32'(buf_wr_en), t.exp_wr ? 32'(4'b0001 << t.ep) : 32'h0);
                pulse_dat(t.good);
                check(VTAG[v], "hs valid", 32'(hs_tx_valid), 32'(t.exp_hs != 8'h00));
                if (t.exp_hs != 8'h00) check(VTAG[v], "hs pid", 32'(hs_tx_pid), 32'(t.exp_hs));
            end
            check(VTAG[v], "full", 32'(ep_full[t.ep]), 32'(t.exp_full));
            check(VTAG[v], "irq", 32'(ep_irq[t.ep]), 32'(t.exp_irq));
            tick();
        end

        // R2: broken PID check nibble is ignored
        preset(0, 1'b1);
        send_tok(8'h99, ADDR, 4'd0);
        check("R2", "data_tx_en", 32'(data_tx_en), 32'h0);
        check("R2", "hs valid", 32'(hs_tx_valid), 32'h0);

        // R3: wrong address is ignored
        send_tok(8'h69, ADDR ^ 7'h01, 4'd0);
        check("R3", "data_tx_en", 32'(data_tx_en), 32'h0);
        check("R3", "hs valid", 32'(hs_tx_valid), 32'h0);

        // R6/R8: no ACK, timeout, late ACK, resend
        preset(1, 1'b1);
        send_tok(8'h69, ADDR, 4'd1);
        check("R4", "data_tx_en", 32'(data_tx_en), 32'h1);
        pulse_tx();
        check("R6", "full before ack", 32'(ep_full[1]), 32'h1);
        check("R6", "irq before ack", 32'(ep_irq[1]), 32'h0);
        repeat (TMO + 2) tick();
        pulse_hs(8'hD2);
        check("R8", "full after late ack", 32'(ep_full[1]), 32'h1);
        check("R8", "irq after late ack", 32'(ep_irq[1]), 32'h0);
        check("R8", "idle data_tx_en", 32'(data_tx_en), 32'h0);
        send_tok(8'h69, ADDR, 4'd1);
        check("R8", "resend data_tx_en", 32'(data_tx_en), 32'h1);
        check("R8", "resend rd_en", 32'(buf_rd_en), 32'h2);
        pulse_tx();
        pulse_hs(8'hD2);
        check("R6", "full after ack", 32'(ep_full[1]), 32'h0);
        check("R6", "irq after ack", 32'(ep_irq[1]), 32'h1);

        // R13: completion beats a same-cycle clear
        preset(1, 1'b0);
        send_tok(8'hE1, ADDR, 4'd1);
        irq_clr[1] = 1'b1;
        pulse_dat(1'b1);
        irq_clr = '0;
        check("R13", "irq set wins", 32'(ep_irq[1]), 32'h1);
        check("R9", "full after out", 32'(ep_full[1]), 32'h1);
        irq_clr[1] = 1'b1; tick(); irq_clr = '0;
        check("R13", "irq cleared", 32'(ep_irq[1]), 32'h0);
        check("R13", "full kept by clear", 32'(ep_full[1]), 32'h1);
        cpu_drain[1] = 1'b1; tick(); cpu_drain = '0;
        check("R13", "drain", 32'(ep_full[1]), 32'h0);
        cpu_fill[3] = 1'b1; tick(); cpu_fill = '0;
        check("R13", "fill", 32'(ep_full[3]), 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule